// File: doc/BRIEF.md
# Multi-Channel Threshold Watchdog Monitor

This block sits beside a multi-channel conversion engine and checks every result against one programmable window. Each sample carries a channel index and two data words: the main conversion result and a faster, coarser watchdog result. A single source-select input picks which word is compared. If the selected word is strictly above the upper bound, the high-breach flag of that channel is set. If it is strictly below the lower bound, the low-breach flag of that channel is set. Values and bounds are signed two's complement numbers.

The flags are sticky. Software clears them by pulsing a clear strobe with a one in each bit to be cleared. A per-channel enable mask decides which channels may raise flags at all. A summary output goes high whenever any flag of any channel is set, so a single interrupt line can be driven from it.

Samples arrive on a valid/ready stream. The block never applies back-pressure. `s_ready` is low only while reset is asserted, and it is high from the first clock edge after reset is released. A sample is taken on every cycle where `s_valid` and `s_ready` are both high. The bounds, the mask, the source select and the clear inputs are plain level or strobe pins.

Top module: `thr_watch`

## Requirements
- R1: While reset is asserted, and on release of reset, all high flags, all low flags and `any_flag` are 0.
- R2: When a sample is accepted and its selected data is strictly greater than `thr_hi` (signed), bit `s_chan` of `hi_flags` is 1 from the next clock cycle.
- R3: When a sample is accepted and its selected data is strictly less than `thr_lo` (signed), bit `s_chan` of `lo_flags` is 1 from the next clock cycle.
- R4: Data equal to a bound is not a breach. The comparison is two's complement signed, so -1 is below 0.
- R5: With `src_sel` = 0 the compared word is `s_main`. With `src_sel` = 1 it is `s_fast`. The word that is not selected has no effect.
- R6: A sample on a channel whose `chan_mask` bit is 0 changes no flag.
- R7: A cycle with `s_valid` low changes no flag.
- R8: A cycle with `clr_we` high clears every flag whose bit is 1 in `clr_hi` (for high flags) or in `clr_lo` (for low flags). Bits written as 0 leave their flags unchanged. The clear is visible on the next cycle.
- R9: If a breach sets a flag in the same cycle that a clear targets it, the flag ends up set.
- R10: `any_flag` equals the OR of all bits of `hi_flags` and `lo_flags`, in the same cycle.
- R11: A set flag stays set through later in-window samples until it is cleared.
- R12: `s_ready` is 1 on every cycle after reset release. The block never back-pressures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample accept; high whenever out of reset |
| s_chan | input | 3 | Channel index of the sample |
| s_main | input | 24 | Main conversion result, signed |
| s_fast | input | 24 | Fast watchdog result, signed |
| src_sel | input | 1 | 0 compares `s_main`, 1 compares `s_fast` |
| chan_mask | input | 8 | Per-channel monitor enable |
| thr_hi | input | 24 | Upper bound, signed |
| thr_lo | input | 24 | Lower bound, signed |
| clr_we | input | 1 | Clear strobe |
| clr_hi | input | 8 | High-flag bits to clear when `clr_we` is high |
| clr_lo | input | 8 | Low-flag bits to clear when `clr_we` is high |
| hi_flags | output | 8 | Sticky high-breach flags, one per channel |
| lo_flags | output | 8 | Sticky low-breach flags, one per channel |
| any_flag | output | 1 | OR of all flags |

## Verification
The bench probes data exactly at each bound and at one step beyond it. An off-by-one comparator would flag equal values or miss the first breaching value. It uses negative bounds together with positive data, where an unsigned compare inverts the result. It sends in-window main data with out-of-window fast data, and the reverse, so that a swapped or ignored source select sets the wrong flags. It also drives a breach and a clear of the same bit in the same cycle, and clears only some bits, so that a priority inversion or a clear that spills into neighbouring bits shows up as a flag mismatch.

// File: rtl/thr_watch_pkg.sv
package thr_watch_pkg;
  typedef struct packed {
    logic above;
    logic below;
  } breach_t;

  localparam int unsigned DEF_DATA_W = 24;
  localparam int unsigned DEF_NUM_CH = 8;
endpackage

// File: rtl/thr_watch_cmp.sv
module thr_watch_cmp
  import thr_watch_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W
) (
  input  logic              use_fast,
  input  logic [DATA_W-1:0] main_word,
  input  logic [DATA_W-1:0] fast_word,
  input  logic [DATA_W-1:0] bound_hi,
  input  logic [DATA_W-1:0] bound_lo,
  output breach_t           result
);
  logic signed [DATA_W-1:0] pick;
  logic signed [DATA_W-1:0] s_hi;
  logic signed [DATA_W-1:0] s_lo;

  always_comb begin
    pick = use_fast ? $signed(fast_word) : $signed(main_word);
    s_hi = $signed(bound_hi);
    s_lo = $signed(bound_lo);
    result.above = (pick > s_hi);
    result.below = (pick < s_lo);
  end
endmodule

// File: rtl/thr_watch_flags.sv
module thr_watch_flags
  import thr_watch_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_vec,
  input  logic              clr_en,
  input  logic [NUM_CH-1:0] clr_vec,
  output logic [NUM_CH-1:0] flags
);
  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          flags[g] <= 1'b0;
        end else if (set_vec[g]) begin
          flags[g] <= 1'b1;
        end else if (clr_en && clr_vec[g]) begin
          flags[g] <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/thr_watch.sv
module thr_watch
  import thr_watch_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [CH_W-1:0]   s_chan,
  input  logic [DATA_W-1:0] s_main,
  input  logic [DATA_W-1:0] s_fast,
  input  logic              src_sel,
  input  logic [NUM_CH-1:0] chan_mask,
  input  logic [DATA_W-1:0] thr_hi,
  input  logic [DATA_W-1:0] thr_lo,
  input  logic              clr_we,
  input  logic [NUM_CH-1:0] clr_hi,
  input  logic [NUM_CH-1:0] clr_lo,
  output logic [NUM_CH-1:0] hi_flags,
  output logic [NUM_CH-1:0] lo_flags,
  output logic              any_flag
);
  logic              rdy_q;
  logic              take;
  breach_t           cmp_res;
  logic [NUM_CH-1:0] set_hi;
  logic [NUM_CH-1:0] set_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign s_ready = rdy_q;
  assign take    = s_valid && rdy_q;

  thr_watch_cmp #(.DATA_W(DATA_W)) u_cmp (
    .use_fast  (src_sel),
    .main_word (s_main),
    .fast_word (s_fast),
    .bound_hi  (thr_hi),
    .bound_lo  (thr_lo),
    .result    (cmp_res)
  );

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_dec
      logic hit;
      assign hit       = take && chan_mask[c] && (s_chan == CH_W'(c));
      assign set_hi[c] = hit && cmp_res.above;
      assign set_lo[c] = hit && cmp_res.below;
    end
  endgenerate

  thr_watch_flags #(.NUM_CH(NUM_CH)) u_hi (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_hi),
    .clr_en  (clr_we),
    .clr_vec (clr_hi),
    .flags   (hi_flags)
  );

  thr_watch_flags #(.NUM_CH(NUM_CH)) u_lo (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_lo),
    .clr_en  (clr_we),
    .clr_vec (clr_lo),
    .flags   (lo_flags)
  );

  assign any_flag = (|hi_flags) || (|lo_flags);
endmodule

// File: rtl/thr_watch_chk.sv
module thr_watch_chk #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CH_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic [CH_W-1:0]   s_chan,
  input logic [NUM_CH-1:0] chan_mask,
  input logic              clr_we,
  input logic [NUM_CH-1:0] clr_hi,
  input logic [NUM_CH-1:0] clr_lo,
  input logic [NUM_CH-1:0] hi_flags,
  input logic [NUM_CH-1:0] lo_flags
);
  // R6
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !chan_mask[s_chan] && !clr_we) |=> ($stable(hi_flags) && $stable(lo_flags)));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_valid && !clr_we) |=> ($stable(hi_flags) && $stable(lo_flags)));

  // R8
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !s_valid) |=> (((hi_flags & $past(clr_hi)) == '0) && ((lo_flags & $past(clr_lo)) == '0)));

  // R11
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> (((hi_flags & $past(hi_flags)) == $past(hi_flags)) &&
                 ((lo_flags & $past(lo_flags)) == $past(lo_flags))));

  // R12
  always_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> s_ready);
endmodule

bind thr_watch thr_watch_chk #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .s_chan    (s_chan),
  .chan_mask (chan_mask),
  .clr_we    (clr_we),
  .clr_hi    (clr_hi),
  .clr_lo    (clr_lo),
  .hi_flags  (hi_flags),
  .lo_flags  (lo_flags)
);

// File: tb/sim_thr_watch.sv
module sim_thr_watch;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [2:0]  s_chan = '0;
  logic [23:0] s_main = '0;
  logic [23:0] s_fast = '0;
  logic        src_sel = 1'b0;
  logic [7:0]  chan_mask = 8'hFF;
  logic [23:0] thr_hi = 24'd100;
  logic [23:0] thr_lo = -24'sd100;
  logic        clr_we = 1'b0;
  logic [7:0]  clr_hi = '0;
  logic [7:0]  clr_lo = '0;
  logic [7:0]  hi_flags, lo_flags;
  logic        any_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [7:0] exp_hi = '0, exp_lo = '0;
  logic       model_live = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thr_watch u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_chan(s_chan), .s_main(s_main), .s_fast(s_fast), .src_sel(src_sel),
    .chan_mask(chan_mask), .thr_hi(thr_hi), .thr_lo(thr_lo), .clr_we(clr_we),
    .clr_hi(clr_hi), .clr_lo(clr_lo), .hi_flags(hi_flags), .lo_flags(lo_flags),
    .any_flag(any_flag)
  );

  // Behavioural reference: integers for the signed comparison
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_hi <= '0; exp_lo <= '0; model_live <= 1'b0;
    end else begin
      logic [7:0] nh, nl;
      longint d, h, l;
      nh = exp_hi; nl = exp_lo;
      if (clr_we) begin nh = nh & ~clr_hi; nl = nl & ~clr_lo; end
      if (s_valid && model_live && chan_mask[s_chan]) begin
        d = src_sel ? longint'($signed(s_fast)) : longint'($signed(s_main));
        h = longint'($signed(thr_hi));
        l = longint'($signed(thr_lo));
        if (d > h) nh[s_chan] = 1'b1;
        if (d < l) nl[s_chan] = 1'b1;
      end
      exp_hi <= nh; exp_lo <= nl; model_live <= 1'b1;
    end
  end

  task automatic compare(input string req);
    logic exp_any;
    exp_any = (|exp_hi) || (|exp_lo);
    n_chk++;
    if (hi_flags !== exp_hi || lo_flags !== exp_lo || any_flag !== exp_any ||
        s_ready !== model_live) begin
      n_fail++;
      $display("FAIL %s: hi=%h lo=%h any=%b rdy=%b, expected hi=%h lo=%h any=%b rdy=%b",
               req, hi_flags, lo_flags, any_flag, s_ready, exp_hi, exp_lo, exp_any, model_live);
    end
  endtask

  // Check the effect of the previous cycle, then drive the next one
  task automatic cyc(input string req, input logic v, input logic [2:0] ch,
                     input logic [23:0] dm, input logic [23:0] df,
                     input logic cw, input logic [7:0] ch_h, input logic [7:0] ch_l);
    @(negedge clk);
    compare(cur_req);
    cur_req = req;
    s_valid = v; s_chan = ch; s_main = dm; s_fast = df;
    clr_we = cw; clr_hi = ch_h; clr_lo = ch_l;
  endtask

  task automatic idle(input string req);
    cyc(req, 1'b0, 3'd0, 24'd0, 24'd0, 1'b0, 8'h00, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    idle("R12");
    idle("R1");
    // R2 / R4: bound and one step beyond
    cyc("R4", 1, 3'd0, 24'd100, 24'd0, 0, 0, 0);
    cyc("R2", 1, 3'd0, 24'd101, 24'd0, 0, 0, 0);
    cyc("R3", 1, 3'd1, -24'sd101, 24'd0, 0, 0, 0);
    cyc("R4", 1, 3'd2, -24'sd100, 24'd0, 0, 0, 0);
    idle("R10");
    // R4: signed bounds, negative upper bound
    cyc("R4", 1, 3'd0, 24'd0, 24'd0, 1, 8'hFF, 8'hFF);
    thr_hi = -24'sd5; thr_lo = -24'sd20;
    cyc("R4", 1, 3'd3, 24'd3, 24'd0, 0, 0, 0);
    cyc("R4", 1, 3'd4, -24'sd5, 24'd0, 0, 0, 0);
    cyc("R4", 1, 3'd5, -24'sd21, 24'd0, 0, 0, 0);
    cyc("R4", 1, 3'd6, 24'h800000, 24'd0, 0, 0, 0);
    cyc("R8", 0, 3'd0, 24'd0, 24'd0, 1, 8'hFF, 8'hFF);
    thr_hi = 24'd50; thr_lo = -24'sd50;
    idle("R1");
    // R5: source select
    cyc("R5", 1, 3'd2, 24'd0, 24'd900, 0, 0, 0);
    src_sel = 1'b1;
    cyc("R5", 1, 3'd3, 24'd900, 24'd0, 0, 0, 0);
    cyc("R5", 1, 3'd4, 24'd0, -24'sd900, 0, 0, 0);
    src_sel = 1'b0;
    cyc("R5", 1, 3'd5, -24'sd900, 24'd0, 0, 0, 0);
    // R6: masked channel
    chan_mask = 8'b1111_0111;
    cyc("R6", 1, 3'd3, 24'd900, 24'd0, 0, 0, 0);
    cyc("R6", 1, 3'd3, -24'sd900, 24'd0, 0, 0, 0);
    chan_mask = 8'hFF;
    // R7: breach data with valid low
    cyc("R7", 0, 3'd7, 24'd900, 24'd900, 0, 0, 0);
    cyc("R7", 0, 3'd6, -24'sd900, 24'd0, 0, 0, 0);
    // R11: sticky through in-window samples
    cyc("R11", 1, 3'd4, 24'd0, 24'd0, 0, 0, 0);
    cyc("R11", 1, 3'd5, 24'd10, 24'd0, 0, 0, 0);
    // R8: partial clears
    cyc("R8", 0, 3'd0, 24'd0, 24'd0, 1, 8'h00, 8'h10);
    cyc("R8", 0, 3'd0, 24'd0, 24'd0, 1, 8'h00, 8'h00);
    // R9: set beats clear on the same bit
    cyc("R9", 1, 3'd7, 24'd60, 24'd0, 1, 8'h80, 8'h20);
    cyc("R9", 1, 3'd1, -24'sd60, 24'd0, 1, 8'h00, 8'h02);
    idle("R10");
    // R10: clear everything, then one flag only
    cyc("R10", 0, 3'd0, 24'd0, 24'd0, 1, 8'hFF, 8'hFF);
    idle("R10");
    cyc("R10", 1, 3'd6, -24'sd51, 24'd0, 0, 0, 0);
    idle("R10");
    cyc("R8", 0, 3'd0, 24'd0, 24'd0, 1, 8'h00, 8'h40);
    idle("R10");
    // loop over channels with high breaches
    for (int k = 0; k < 8; k++) cyc("R2", 1, 3'(k), 24'd51, 24'd0, 0, 0, 0);
    idle("R11");
    idle("R11");
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule